// File: doc/BRIEF.md
# CAN Fault Confinement and Bus-Off Recovery Controller

This block tracks the error standing of one CAN node from events seen at bit level. A bit-time strobe marks each sampled bus bit. The sampled level reads 1 for recessive and 0 for dominant, so a bus whose two wires are shorted together reads as a steady 1. Single-cycle pulses report failed and successful transmissions. From these inputs the block keeps the transmit error count and derives the node's confinement state: error-active, error-passive or bus-off.

While a frame is being received, the block watches for runs of identical bits. A run that reaches the limit is counted as an error, in the same way as a reported transmit failure. Once the count goes past its ceiling, the node is in bus-off. Transmit events and run errors are then ignored. The block counts completed runs of consecutive recessive bits, and when enough runs have completed, the count is cleared and the node returns to error-active.

On a bus that stays recessive the whole cycle repeats. Errors build up again, the node falls back into bus-off, it recovers, and it falls again, with no end.

Top module: `can_fault_confine`

## Requirements
- R1: After reset, `tec` is 0, `node_state` is 2'b00 and `recov_runs` is 0.
- R2: When the node is not in bus-off, a `tx_fail` pulse raises `tec` by 8 at the next clock edge.
- R3: When the node is not in bus-off, a `tx_done` pulse lowers `tec` by 1. The count stays at 0 when it is already 0. If `tx_fail` and `tx_done` arrive in the same cycle, only the increase of 8 applies.
- R4: `node_state` is 2'b00 (active) while `tec` < 128. It is 2'b01 (passive) while 128 <= `tec` <= 255 and the node is not in bus-off. It is 2'b10 in bus-off. The code 2'b11 never appears.
- R5: While `rx_frame` is high, the sixth consecutive `bit_tick` at the same `bus_rx` level adds 8 to `tec`, and the run then starts again from zero. A change of level restarts the run at length 1. A cycle with `rx_frame` low clears the run. A run error and a `tx_fail` in the same cycle add 8 only once.
- R6: Bus-off begins in the cycle where an increase takes `tec` above 255. In bus-off, `tec` holds its value, and `tx_fail`, `tx_done` and bit runs have no effect.
- R7: In bus-off, each 11 consecutive ticks with `bus_rx`=1 increment `recov_runs` by one. A tick with `bus_rx`=0 restarts the current run of 11 and leaves `recov_runs` unchanged. Cycles without `bit_tick` do not count.
- R8: The tick that completes the 128th run sets `tec` to 0, `node_state` to 2'b00 and `recov_runs` to 0, all at the same clock edge.
- R9: With `bus_rx` held at 1, `rx_frame` held high and a tick every cycle, the node starting from `tec`=0 reaches bus-off after 192 ticks. It returns to active after 1408 more ticks, and it reaches bus-off again after another 192 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe marking a sampled bit time |
| bus_rx | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| rx_frame | input | 1 | High while a frame is being received (enables run checks) |
| tx_fail | input | 1 | One-cycle pulse: transmission failed |
| tx_done | input | 1 | One-cycle pulse: transmission succeeded |
| node_state | output | 2 | 00 active, 01 passive, 10 bus-off |
| tec | output | TEC_W (9) | Transmit error count |
| recov_runs | output | RUNS_W (8) | Completed recessive runs during bus-off |

## Verification
The bench builds the block with its default parameters: a run limit of 6, an error step of 8, a passive threshold of 128, a bus-off ceiling of 255, and recovery after 128 runs of 11 bits. With these values one full shorted-bus cycle, 32 run errors followed by 1408 recovery ticks, finishes in a few thousand clocks. Two complete bus-off entries and one recovery can therefore be run back to back and counted exactly. The same values let random traffic cross the passive and bus-off boundaries many times, with recessive bits weighted heavily enough that recovery also completes.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
   typedef enum logic [1:0] {
      FC_ACTIVE  = 2'b00,
      FC_PASSIVE = 2'b01,
      FC_BUSOFF  = 2'b10
   } fc_state_e;
endpackage

// File: rtl/can_fc_run_det.sv
// Same-level run detector: flags an error when RUN_LIMIT equal bits are seen.
module can_fc_run_det #(
   parameter int RUN_LIMIT = 6,
   localparam int RW = $clog2(RUN_LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   input  logic rx,
   output logic run_err
);
   if (RUN_LIMIT < 2) begin : g_bad_limit
      $error("can_fc_run_det: RUN_LIMIT must be at least 2");
   end

   logic [RW-1:0] run_cnt;
   logic [RW-1:0] run_nxt;
   logic          last_lvl;

   always_comb begin
      run_nxt = (run_cnt != '0 && rx == last_lvl) ? run_cnt + RW'(1) : RW'(1);
      run_err = en && tick && (run_nxt == RW'(RUN_LIMIT));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt  <= '0;
         last_lvl <= 1'b1;
      end else if (!en) begin
         run_cnt  <= '0;
      end else if (tick) begin
         last_lvl <= rx;
         run_cnt  <= run_err ? '0 : run_nxt;
      end
   end

   // R5: the run length never reaches the limit as stored state
   a_r5_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt < RW'(RUN_LIMIT));
   // R5: a cycle without enable leaves the run empty
   a_r5_clear_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> run_cnt == '0);
endmodule

// File: rtl/can_fc_recovery.sv
// Bus-off recovery counter: counts runs of RECOV_BITS recessive ticks.
module can_fc_recovery #(
   parameter int RECOV_BITS = 11,
   parameter int RECOV_RUNS = 128,
   localparam int BW = $clog2(RECOV_BITS),
   localparam int CW = $clog2(RECOV_RUNS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          tick,
   input  logic          rx,
   output logic [CW-1:0] runs,
   output logic          done
);
   if (RECOV_BITS < 2) begin : g_bad_bits
      $error("can_fc_recovery: RECOV_BITS must be at least 2");
   end
   if (RECOV_RUNS < 1) begin : g_bad_runs
      $error("can_fc_recovery: RECOV_RUNS must be at least 1");
   end

   logic [BW-1:0] bit_cnt;
   logic          run_end;

   assign run_end = en && tick && rx && (bit_cnt == BW'(RECOV_BITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
      end else if (!en) begin
         bit_cnt <= '0;
      end else if (tick) begin
         if (!rx || run_end) bit_cnt <= '0;
         else                bit_cnt <= bit_cnt + BW'(1);
      end
   end

   if (RECOV_RUNS == 1) begin : g_single_run
      assign runs = '0;
      assign done = run_end;
   end else begin : g_multi_run
      logic [CW-1:0] run_cnt;
      assign done = run_end && (run_cnt == CW'(RECOV_RUNS - 1));
      assign runs = run_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       run_cnt <= '0;
         else if (!en)     run_cnt <= '0;
         else if (done)    run_cnt <= '0;
         else if (run_end) run_cnt <= run_cnt + CW'(1);
      end
      // R7: completed runs stay below the target as stored state
      a_r7_runs_bound: assert property (@(posedge clk) disable iff (!rst_n)
         run_cnt < CW'(RECOV_RUNS));
   end

   // R7: a dominant tick restarts the bit run and keeps the run count
   a_r7_dominant_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && !rx) |=> (bit_cnt == '0) && $stable(runs));
   // R7: the bit position never passes the run length
   a_r7_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt < BW'(RECOV_BITS));
endmodule

// File: rtl/can_fc_tec.sv
// Transmit error count and confinement state.
module can_fc_tec
   import can_fc_pkg::*;
#(
   parameter int ERR_INC    = 8,
   parameter int PASSIVE_TH = 128,
   parameter int BUSOFF_TH  = 255,
   localparam int TEC_W = $clog2(BUSOFF_TH + ERR_INC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_fail,
   input  logic             tx_done,
   input  logic             run_err,
   input  logic             recov_done,
   output logic [TEC_W-1:0] tec,
   output logic             busoff,
   output fc_state_e        state
);
   if (PASSIVE_TH > BUSOFF_TH || ERR_INC < 1) begin : g_bad_thresh
      $error("can_fc_tec: thresholds or step out of range");
   end

   localparam logic [TEC_W-1:0] INC  = TEC_W'(ERR_INC);
   localparam logic [TEC_W-1:0] PASS = TEC_W'(PASSIVE_TH);
   localparam logic [TEC_W-1:0] CEIL = TEC_W'(BUSOFF_TH);

   logic             err_ev;
   logic             ok_ev;
   logic [TEC_W-1:0] tec_up;

   always_comb begin
      err_ev = !busoff && (tx_fail || run_err);
      ok_ev  = !busoff && tx_done && !err_ev;
      tec_up = tec + INC;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tec    <= '0;
         busoff <= 1'b0;
      end else if (recov_done) begin
         tec    <= '0;
         busoff <= 1'b0;
      end else if (err_ev) begin
         tec    <= tec_up;
         busoff <= tec_up > CEIL;
      end else if (ok_ev && tec != '0) begin
         tec    <= tec - TEC_W'(1);
      end
   end

   always_comb begin
      if (busoff)          state = FC_BUSOFF;
      else if (tec >= PASS) state = FC_PASSIVE;
      else                 state = FC_ACTIVE;
   end

   // R2: a failure outside bus-off raises the count by one step
   a_r2_fail_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!busoff && tx_fail) |=> tec == $past(tec) + INC);
   // R3: the count never wraps below zero
   a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (!busoff && tec == '0 && !tx_fail && !run_err) |=> tec == '0);
   // R6: bus-off freezes the count until recovery
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busoff && !recov_done) |=> busoff && $stable(tec));
   // R6: bus-off only with a count above the ceiling
   a_r6_level: assert property (@(posedge clk) disable iff (!rst_n)
      busoff |-> tec > CEIL);
   // R4: the unused state code never appears
   a_r4_code: assert property (@(posedge clk) disable iff (!rst_n)
      state != 2'b11);
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
   import can_fc_pkg::*;
#(
   parameter int RUN_LIMIT  = 6,
   parameter int ERR_INC    = 8,
   parameter int PASSIVE_TH = 128,
   parameter int BUSOFF_TH  = 255,
   parameter int RECOV_BITS = 11,
   parameter int RECOV_RUNS = 128,
   localparam int TEC_W  = $clog2(BUSOFF_TH + ERR_INC + 1),
   localparam int RUNS_W = $clog2(RECOV_RUNS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              bus_rx,
   input  logic              rx_frame,
   input  logic              tx_fail,
   input  logic              tx_done,
   output logic [1:0]        node_state,
   output logic [TEC_W-1:0]  tec,
   output logic [RUNS_W-1:0] recov_runs
);
   logic      busoff;
   logic      run_err;
   logic      recov_done;
   fc_state_e state;

   can_fc_run_det #(.RUN_LIMIT(RUN_LIMIT)) u_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (rx_frame && !busoff),
      .tick    (bit_tick),
      .rx      (bus_rx),
      .run_err (run_err)
   );

   can_fc_recovery #(.RECOV_BITS(RECOV_BITS), .RECOV_RUNS(RECOV_RUNS)) u_rec (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (busoff),
      .tick (bit_tick),
      .rx   (bus_rx),
      .runs (recov_runs),
      .done (recov_done)
   );

   can_fc_tec #(.ERR_INC(ERR_INC), .PASSIVE_TH(PASSIVE_TH), .BUSOFF_TH(BUSOFF_TH)) u_tec (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_fail    (tx_fail),
      .tx_done    (tx_done),
      .run_err    (run_err),
      .recov_done (recov_done),
      .tec        (tec),
      .busoff     (busoff),
      .state      (state)
   );

   assign node_state = state;

   // R8: leaving bus-off always lands on a cleared count and run tally
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busoff) |-> (tec == '0) && (recov_runs == '0) && (node_state == 2'b00));
   // R7: the run tally only moves during bus-off
   a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busoff |-> recov_runs == '0);
endmodule

// File: tb/tb_can_fault_confine.sv
`timescale 1ns/1ps
module tb_can_fault_confine;
   localparam int RUN_LIMIT  = 6;
   localparam int ERR_INC    = 8;
   localparam int PASSIVE_TH = 128;
   localparam int BUSOFF_TH  = 255;
   localparam int RECOV_BITS = 11;
   localparam int RECOV_RUNS = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0, bus_rx = 1'b1, rx_frame = 1'b0;
   logic       tx_fail = 1'b0, tx_done = 1'b0;
   logic [1:0] node_state;
   logic [8:0] tec;
   logic [7:0] recov_runs;

   int checks = 0, failures = 0;
   bit done_flag = 0;

   // reference model state
   int m_tec = 0, m_off = 0, m_run = 0, m_last = 1, m_bc = 0, m_rc = 0;

   always #2.5 clk = ~clk;

   can_fault_confine #(
      .RUN_LIMIT(RUN_LIMIT), .ERR_INC(ERR_INC), .PASSIVE_TH(PASSIVE_TH),
      .BUSOFF_TH(BUSOFF_TH), .RECOV_BITS(RECOV_BITS), .RECOV_RUNS(RECOV_RUNS)
   ) dut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bus_rx(bus_rx),
      .rx_frame(rx_frame), .tx_fail(tx_fail), .tx_done(tx_done),
      .node_state(node_state), .tec(tec), .recov_runs(recov_runs)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_state();
      if (m_off != 0) return 2;
      if (m_tec >= PASSIVE_TH) return 1;
      return 0;
   endfunction

   // one clock with the given inputs; model advanced from requirements
   task automatic cyc(input bit t, input bit r, input bit f, input bit fl,
                      input bit dn, input string tag);
      int rerr, rdone, nrun, err, ok;
      bit_tick = t; bus_rx = r; rx_frame = f; tx_fail = fl; tx_done = dn;
      rerr = 0; rdone = 0;
      if (f && m_off == 0) begin
         if (t) begin
            nrun = (m_run != 0 && r == m_last) ? m_run + 1 : 1;
            m_last = r;
            if (nrun == RUN_LIMIT) begin rerr = 1; m_run = 0; end
            else m_run = nrun;
         end
      end else m_run = 0;
      if (m_off == 0) begin
         m_bc = 0; m_rc = 0;
      end else if (t) begin
         if (!r) m_bc = 0;
         else if (m_bc == RECOV_BITS - 1) begin
            m_bc = 0;
            if (m_rc == RECOV_RUNS - 1) begin rdone = 1; m_rc = 0; end
            else m_rc++;
         end else m_bc++;
      end
      err = (m_off == 0) && (fl || rerr);
      ok  = (m_off == 0) && dn && !err;
      if (rdone) begin m_tec = 0; m_off = 0; end
      else if (err) begin
         m_tec += ERR_INC;
         if (m_tec > BUSOFF_TH) m_off = 1;
      end else if (ok && m_tec > 0) m_tec--;
      @(negedge clk);
      chk(tec == 9'(m_tec), {tag, " tec"}, tec, m_tec);
      chk(node_state == 2'(exp_state()), {tag, " state"}, node_state, exp_state());
      chk(recov_runs == 8'(m_rc), {tag, " runs"}, recov_runs, m_rc);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired (R9 sequence hung) actual=0 expected=1");
      finish_run();
   end

   initial begin
      int n;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(tec == 0, "R1 tec", tec, 0);
      chk(node_state == 2'b00, "R1 state", node_state, 0);
      chk(recov_runs == 0, "R1 runs", recov_runs, 0);

      // R2 single failure
      cyc(0, 1, 0, 1, 0, "R2");
      chk(tec == 8, "R2 step", tec, 8);
      // R3 decrement and floor
      for (int i = 0; i < 9; i++) cyc(0, 1, 0, 0, 1, "R3");
      chk(tec == 0, "R3 floor", tec, 0);
      cyc(0, 1, 0, 1, 1, "R3");
      chk(tec == 8, "R3 fail wins", tec, 8);
      // R4 passive boundary
      for (int i = 0; i < 14; i++) cyc(0, 1, 0, 1, 0, "R4");
      chk(node_state == 2'b00 && tec == 120, "R4 still active", tec, 120);
      cyc(0, 1, 0, 1, 0, "R4");
      chk(node_state == 2'b01, "R4 passive", node_state, 1);

      // R5 runs: alternating bits give nothing
      for (int i = 0; i < 10; i++) cyc(1, (i % 2) == 0, 1, 0, 0, "R5");
      chk(tec == 128, "R5 alternating", tec, 128);
      for (int i = 0; i < 6; i++) cyc(1, 1, 1, 0, 0, "R5");
      chk(tec == 136, "R5 six same", tec, 136);
      for (int i = 0; i < 5; i++) cyc(1, 1, 1, 0, 0, "R5");
      cyc(0, 1, 0, 0, 0, "R5");
      for (int i = 0; i < 5; i++) cyc(1, 1, 1, 0, 0, "R5");
      chk(tec == 136, "R5 frame drop clears", tec, 136);
      cyc(1, 1, 1, 1, 0, "R5");
      chk(tec == 144, "R5 merged with fail", tec, 144);

      // R6 into bus-off
      for (int i = 0; i < 13; i++) cyc(0, 1, 0, 1, 0, "R6");
      chk(node_state == 2'b01 && tec == 248, "R6 below ceiling", tec, 248);
      cyc(0, 1, 0, 1, 0, "R6");
      chk(node_state == 2'b10 && tec == 256, "R6 bus-off", tec, 256);
      cyc(0, 0, 0, 1, 0, "R6");
      cyc(0, 0, 0, 0, 1, "R6");
      for (int i = 0; i < 7; i++) cyc(1, 0, 1, 0, 0, "R6");
      chk(tec == 256 && node_state == 2'b10, "R6 ignored", tec, 256);

      // R7 recovery runs
      for (int i = 0; i < 10; i++) cyc(1, 1, 0, 0, 0, "R7");
      cyc(0, 1, 0, 0, 0, "R7");
      cyc(1, 0, 0, 0, 0, "R7");
      chk(recov_runs == 0, "R7 dominant restart", recov_runs, 0);
      for (int i = 0; i < 11; i++) cyc(1, 1, 0, 0, 0, "R7");
      chk(recov_runs == 1, "R7 one run", recov_runs, 1);
      cyc(1, 0, 0, 0, 0, "R7");
      chk(recov_runs == 1, "R7 run kept", recov_runs, 1);

      // R8 complete recovery
      for (int i = 0; i < (RECOV_RUNS - 1) * RECOV_BITS - 1; i++) cyc(1, 1, 0, 0, 0, "R8");
      chk(node_state == 2'b10 && recov_runs == 127, "R8 one tick short", recov_runs, 127);
      cyc(1, 1, 0, 0, 0, "R8");
      chk(node_state == 2'b00 && tec == 0 && recov_runs == 0, "R8 recovered", tec, 0);

      // R9 shorted bus: fall, recover, fall again
      n = 0;
      while (node_state != 2'b10 && n < 1000) begin cyc(1, 1, 1, 0, 0, "R9"); n++; end
      chk(n == 192, "R9 first fall", n, 192);
      n = 0;
      while (node_state != 2'b00 && n < 3000) begin cyc(1, 1, 1, 0, 0, "R9"); n++; end
      chk(n == 1408, "R9 recovery", n, 1408);
      n = 0;
      while (node_state != 2'b10 && n < 1000) begin cyc(1, 1, 1, 0, 0, "R9"); n++; end
      chk(n == 192, "R9 second fall", n, 192);

      // reset, then random traffic against the model (R2 R3 R4 R5 R6 R7 R8)
      rst_n = 1'b0;
      m_tec = 0; m_off = 0; m_run = 0; m_last = 1; m_bc = 0; m_rc = 0;
      @(negedge clk);
      rst_n = 1'b1;
      begin
         bit fr = 0;
         for (int i = 0; i < 20000; i++) begin
            if ($urandom % 20 == 0) fr = !fr;
            cyc($urandom % 2 == 0, $urandom % 6 != 0, fr,
                $urandom % 10 == 0, $urandom % 3 == 0, "R5 random");
         end
      end
      finish_run();
   end
endmodule